// File: doc/BRIEF.md
# SMBus Status and Control Flag Register

This block keeps the eight status and control flags of a two-wire serial bus controller. The flags cover master ownership, transmit direction, the software start and stop requests, the acknowledge request, lost arbitration, the acknowledge value and the serial interrupt. A separate bus engine reports what happens on the wire through one-cycle event strobes on the system clock. The block turns those strobes into flag updates using a fixed rule for each flag.

Software reads the flag byte at any time and writes it through a simple write strobe. Only the start-request, stop-request, ack and interrupt bits accept software writes. When a hardware event and a software write target the same flag in the same cycle, the hardware event wins. Two pieces of context are tracked internally: whether the data register was loaded before the next frame began, and whether the block is currently addressed as a slave.

Top module: `smbf_flags`

## Requirements
- R1: A synchronous active-high reset clears all eight flags to 0 at the next rising edge. The flag byte is laid out as follows: bit 0 master, bit 1 transmit-mode, bit 2 interrupt, bit 3 ack, bit 4 arbitration-lost, bit 5 ack-request, bit 6 start-request, bit 7 stop-request.
- R2: The master flag becomes 1 after a generated START. It becomes 0 after a generated STOP or after any loss of arbitration.
- R3: The transmit-mode flag becomes 1 after a generated START, or at a frame start if the data register was written since the previous frame start. It becomes 0 at a frame start with no such write, after a detected START, or after any loss of arbitration.
- R4: The start-request flag becomes 1 when a START plus a matching address is received. No other hardware event clears it. Only a software write clears it.
- R5: The stop-request flag becomes 1 in two cases: a STOP is detected while the block is addressed as a slave, or a STOP is detected while the block is master and not generating one itself (arbitration lost to a STOP). It becomes 0 when a STOP is generated while it is set.
- R6: The ack-request flag becomes 1 after a byte is received and becomes 0 after each ACK cycle.
- R7: On an ACK cycle, the ack flag becomes 1 if the sampled ACK level is low and 0 if it is high.
- R8: The arbitration-lost flag becomes 1 in three cases: a START is detected while master with start-request low; SCL is low during a STOP or repeated-START attempt; SDA is low while driving a '1' in a data bit. SDA faults during ACK bits are ignored. The flag clears when software writes the interrupt bit as 0.
- R9: The interrupt flag becomes 1 on any of these: a generated START, any arbitration loss, a sent byte with its ACK received, a received byte, a received address match, or a STOP that sets stop-request. Only a software write clears it.
- R10: A hardware set event overrides a software write to the same flag in the same cycle.
- R11: Software writes leave the master, transmit-mode, ack-request and arbitration-lost bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_gen | input | 1 | This block generated a START |
| ev_stop_gen | input | 1 | This block generated a STOP |
| ev_start_det | input | 1 | A START from another master was seen on the bus |
| ev_stop_det | input | 1 | A STOP was seen on the bus |
| ev_addr_match | input | 1 | START plus a matching address and direction bit received |
| ev_byte_rx | input | 1 | A data byte was received |
| ev_byte_tx_done | input | 1 | A byte was sent and its ACK/NACK was received |
| ev_ack_cycle | input | 1 | An ACK bit cycle completed |
| ack_level | input | 1 | Sampled SDA level in the ACK cycle |
| ev_frame_begin | input | 1 | A byte frame begins |
| dat_wr | input | 1 | Software wrote the data register |
| fault_scl_low | input | 1 | SCL held low during a STOP or repeated-START attempt |
| fault_sda_low | input | 1 | SDA read low while a '1' was driven |
| in_ack_bit | input | 1 | The current bit is an ACK bit |
| sw_we | input | 1 | Software write strobe for the flag byte |
| sw_wdata | input | 8 | Software write data |
| flags | output | 8 | Registered flag byte |

## Verification
A wrong internal state shows up in the flag byte at the first rising edge after the triggering strobe. The context trackers are the exception. A stale data-loaded state shows up only at the next frame start, as the wrong transmit-mode bit. A stale slave-selected state shows up only when the next STOP sets or fails to set stop-request together with the interrupt bit. The bench therefore checks after every edge, and it runs each context through both values before the event that exposes it.

// File: rtl/smbf_pkg.sv
`timescale 1ns/1ps
package smbf_pkg;
  localparam int FLAG_W = 8;
  localparam int B_MST  = 0;
  localparam int B_TXM  = 1;
  localparam int B_IRQ  = 2;
  localparam int B_ACK  = 3;
  localparam int B_ARB  = 4;
  localparam int B_AKRQ = 5;
  localparam int B_STA  = 6;
  localparam int B_STO  = 7;
  localparam logic [FLAG_W-1:0] SW_MASK =
    (FLAG_W'(1) << B_STA) | (FLAG_W'(1) << B_STO) |
    (FLAG_W'(1) << B_ACK) | (FLAG_W'(1) << B_IRQ);

  typedef struct packed {
    logic start_gen;
    logic stop_gen;
    logic start_det;
    logic stop_det;
    logic addr_match;
    logic byte_rx;
    logic byte_tx_done;
    logic ack_cycle;
    logic ack_level;
    logic frame_begin;
    logic dat_wr;
    logic scl_low;
    logic sda_low;
    logic in_ack_bit;
  } smbf_ev_t;
endpackage

// File: rtl/smbf_flag_cell.sv
`timescale 1ns/1ps
module smbf_flag_cell #(
  parameter bit WRITABLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_val,
  output logic q
);
  logic sw_take;
  logic q_nxt;

  assign sw_take = WRITABLE ? sw_we : 1'b0;

  always_comb begin
    if (hw_set)       q_nxt = 1'b1;
    else if (hw_clr)  q_nxt = 1'b0;
    else if (sw_take) q_nxt = sw_val;
    else              q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/smbf_arb_qual.sv
`timescale 1ns/1ps
module smbf_arb_qual (
  input  logic start_det,
  input  logic stop_det,
  input  logic stop_gen,
  input  logic scl_low,
  input  logic sda_low,
  input  logic in_ack_bit,
  input  logic is_master,
  input  logic start_req,
  output logic arb_fault,
  output logic stop_loss,
  output logic arb_any
);
  logic rstart_clash;
  logic sda_clash;

  assign rstart_clash = start_det & is_master & ~start_req;
  assign sda_clash    = sda_low & ~in_ack_bit;
  assign arb_fault    = rstart_clash | scl_low | sda_clash;
  assign stop_loss    = stop_det & is_master & ~stop_gen;
  assign arb_any      = arb_fault | stop_loss;
endmodule

// File: rtl/smbf_ctx_track.sv
`timescale 1ns/1ps
module smbf_ctx_track (
  input  logic clk,
  input  logic rst,
  input  logic dat_wr,
  input  logic frame_begin,
  input  logic addr_match,
  input  logic is_master,
  input  logic stop_det,
  input  logic start_gen,
  output logic loaded,
  output logic slave_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loaded    <= 1'b0;
      slave_sel <= 1'b0;
    end else begin
      if (frame_begin)  loaded <= dat_wr;
      else if (dat_wr)  loaded <= 1'b1;

      if (stop_det || start_gen)          slave_sel <= 1'b0;
      else if (addr_match && !is_master)  slave_sel <= 1'b1;
    end
  end
endmodule

// File: rtl/smbf_flags.sv
`timescale 1ns/1ps
module smbf_flags
  import smbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start_gen,
  input  logic              ev_stop_gen,
  input  logic              ev_start_det,
  input  logic              ev_stop_det,
  input  logic              ev_addr_match,
  input  logic              ev_byte_rx,
  input  logic              ev_byte_tx_done,
  input  logic              ev_ack_cycle,
  input  logic              ack_level,
  input  logic              ev_frame_begin,
  input  logic              dat_wr,
  input  logic              fault_scl_low,
  input  logic              fault_sda_low,
  input  logic              in_ack_bit,
  input  logic              sw_we,
  input  logic [FLAG_W-1:0] sw_wdata,
  output logic [FLAG_W-1:0] flags
);
  smbf_ev_t ev;
  logic [FLAG_W-1:0] set_v, clr_v, q;
  logic arb_fault, stop_loss, arb_any;
  logic loaded, slave_sel;
  logic irq_clr_pulse, sto_set;

  assign ev = '{start_gen: ev_start_gen, stop_gen: ev_stop_gen,
                start_det: ev_start_det, stop_det: ev_stop_det,
                addr_match: ev_addr_match, byte_rx: ev_byte_rx,
                byte_tx_done: ev_byte_tx_done, ack_cycle: ev_ack_cycle,
                ack_level: ack_level, frame_begin: ev_frame_begin,
                dat_wr: dat_wr, scl_low: fault_scl_low,
                sda_low: fault_sda_low, in_ack_bit: in_ack_bit};

  smbf_arb_qual u_arb (
    .start_det (ev.start_det),
    .stop_det  (ev.stop_det),
    .stop_gen  (ev.stop_gen),
    .scl_low   (ev.scl_low),
    .sda_low   (ev.sda_low),
    .in_ack_bit(ev.in_ack_bit),
    .is_master (q[B_MST]),
    .start_req (q[B_STA]),
    .arb_fault (arb_fault),
    .stop_loss (stop_loss),
    .arb_any   (arb_any)
  );

  smbf_ctx_track u_ctx (
    .clk        (clk),
    .rst        (rst),
    .dat_wr     (ev.dat_wr),
    .frame_begin(ev.frame_begin),
    .addr_match (ev.addr_match),
    .is_master  (q[B_MST]),
    .stop_det   (ev.stop_det),
    .start_gen  (ev.start_gen),
    .loaded     (loaded),
    .slave_sel  (slave_sel)
  );

  assign irq_clr_pulse = sw_we & ~sw_wdata[B_IRQ];
  assign sto_set       = (ev.stop_det & slave_sel) | stop_loss;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_MST]  = ev.start_gen;
    clr_v[B_MST]  = ev.stop_gen | arb_any;
    set_v[B_TXM]  = ev.start_gen | (ev.frame_begin & loaded);
    clr_v[B_TXM]  = (ev.frame_begin & ~loaded) | ev.start_det | arb_any;
    set_v[B_IRQ]  = ev.start_gen | arb_any | ev.byte_tx_done | ev.byte_rx |
                    ev.addr_match | sto_set;
    set_v[B_ACK]  = ev.ack_cycle & ~ev.ack_level;
    clr_v[B_ACK]  = ev.ack_cycle & ev.ack_level;
    set_v[B_ARB]  = arb_fault;
    clr_v[B_ARB]  = irq_clr_pulse;
    set_v[B_AKRQ] = ev.byte_rx;
    clr_v[B_AKRQ] = ev.ack_cycle;
    set_v[B_STA]  = ev.addr_match;
    set_v[B_STO]  = sto_set;
    clr_v[B_STO]  = ev.stop_gen & q[B_STO];
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_cell
    smbf_flag_cell #(.WRITABLE(SW_MASK[i])) u_cell (
      .clk   (clk),
      .rst   (rst),
      .hw_set(set_v[i]),
      .hw_clr(clr_v[i]),
      .sw_we (sw_we),
      .sw_val(sw_wdata[i]),
      .q     (q[i])
    );
  end

  assign flags = q;
endmodule

// File: rtl/smbf_flags_chk.sv
`timescale 1ns/1ps
module smbf_flags_chk
  import smbf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_start_gen,
  input logic              ev_stop_gen,
  input logic              ev_start_det,
  input logic              ev_stop_det,
  input logic              ev_addr_match,
  input logic              ev_byte_rx,
  input logic              ev_byte_tx_done,
  input logic              ev_ack_cycle,
  input logic              ack_level,
  input logic              fault_scl_low,
  input logic              sw_we,
  input logic [FLAG_W-1:0] flags
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (flags == '0)); // R1

  AST_MASTER_ON_START: assert property (@(posedge clk) disable iff (rst)
    ev_start_gen |=> flags[B_MST]); // R2

  AST_STA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flags[B_STA] && !sw_we) |=> flags[B_STA]); // R4

  AST_AKRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (ev_ack_cycle && !ev_byte_rx) |=> !flags[B_AKRQ]); // R6

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ev_ack_cycle |=> (flags[B_ACK] == !$past(ack_level))); // R7

  AST_ARB_ON_SCL: assert property (@(posedge clk) disable iff (rst)
    fault_scl_low |=> (flags[B_ARB] && !flags[B_MST])); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flags[B_IRQ] && !sw_we) |=> flags[B_IRQ]); // R9

  AST_IRQ_BEATS_SW: assert property (@(posedge clk) disable iff (rst)
    (ev_byte_rx || ev_byte_tx_done || ev_start_gen) |=> flags[B_IRQ]); // R10
endmodule

bind smbf_flags smbf_flags_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .ev_start_gen   (ev_start_gen),
  .ev_stop_gen    (ev_stop_gen),
  .ev_start_det   (ev_start_det),
  .ev_stop_det    (ev_stop_det),
  .ev_addr_match  (ev_addr_match),
  .ev_byte_rx     (ev_byte_rx),
  .ev_byte_tx_done(ev_byte_tx_done),
  .ev_ack_cycle   (ev_ack_cycle),
  .ack_level      (ack_level),
  .fault_scl_low  (fault_scl_low),
  .sw_we          (sw_we),
  .flags          (flags)
);

// File: tb/tb_smbf_flags.sv
`timescale 1ns/1ps
module tb_smbf_flags;
  localparam int SG = 0, SP = 1, SD = 2, PD = 3, AM = 4, RX = 5, TX = 6,
                 AC = 7, AL = 8, FB = 9, DW = 10, SCL = 11, SDA = 12, INACK = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] ev = '0;
  logic sw_we = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  smbf_flags dut (
    .clk(clk), .rst(rst),
    .ev_start_gen(ev[SG]), .ev_stop_gen(ev[SP]), .ev_start_det(ev[SD]),
    .ev_stop_det(ev[PD]), .ev_addr_match(ev[AM]), .ev_byte_rx(ev[RX]),
    .ev_byte_tx_done(ev[TX]), .ev_ack_cycle(ev[AC]), .ack_level(ev[AL]),
    .ev_frame_begin(ev[FB]), .dat_wr(ev[DW]), .fault_scl_low(ev[SCL]),
    .fault_sda_low(ev[SDA]), .in_ack_bit(ev[INACK]),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .flags(flags)
  );

  // driver: applies one cycle of stimulus and queues the flag byte expected after the edge
  task automatic step(input logic [13:0] e, input logic we, input logic [7:0] wd,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    rst = 1'b0;
    ev = e;
    sw_we = we;
    sw_wdata = wd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    ev = '0;
    sw_we = 1'b0;
    exp_q.push_back(8'h00);
    tag_q.push_back(tag);
  endtask

  function automatic logic [13:0] b(input int i);
    return 14'(1) << i;
  endfunction

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (flags !== e) begin
          failures++;
          $display("FAIL %s: flags=%02h expected=%02h", t, flags, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset");
    step('0, 0, 8'h00, 8'h00, "R1 idle after reset");
    step(b(SG), 0, 8'h00, 8'h07, "R2 R3 R9 start generated");
    step('0, 1, 8'h00, 8'h03, "R9 software clears irq");
    step('0, 1, 8'hFF, 8'hCF, "R11 read-only bits ignore write");
    step('0, 1, 8'h00, 8'h03, "R11 read-only bits kept");
    step(b(SP), 0, 8'h00, 8'h02, "R2 stop generated clears master");
    step('0, 1, 8'h80, 8'h82, "R5 software sets stop request");
    step(b(SP), 0, 8'h00, 8'h02, "R5 pending stop generated");
    step(b(FB), 0, 8'h00, 8'h00, "R3 frame without data write");
    step(b(DW), 0, 8'h00, 8'h00, "R3 data written");
    step(b(FB), 0, 8'h00, 8'h02, "R3 frame after data write");
    step(b(SD), 0, 8'h00, 8'h00, "R3 start detected clears tx");
    step(b(AM), 0, 8'h00, 8'h44, "R4 R9 address matched");
    step(b(RX), 0, 8'h00, 8'h64, "R6 byte received");
    step(b(AC), 0, 8'h00, 8'h4C, "R6 R7 ack cycle low");
    step(b(AC) | b(AL), 0, 8'h00, 8'h44, "R7 ack cycle high");
    step(b(PD), 0, 8'h00, 8'hC4, "R5 stop while slave");
    step('0, 1, 8'h00, 8'h00, "R4 R9 software clear");
    step(b(PD), 0, 8'h00, 8'h00, "R5 stop while not addressed");
    step(b(SG), 0, 8'h00, 8'h07, "R2 start generated");
    step('0, 1, 8'h00, 8'h03, "R9 irq cleared");
    step(b(SDA) | b(INACK), 0, 8'h00, 8'h03, "R8 sda fault in ack bit ignored");
    step(b(SDA), 0, 8'h00, 8'h14, "R8 sda fault in data bit");
    step('0, 1, 8'h04, 8'h14, "R8 irq kept keeps arb");
    step('0, 1, 8'h00, 8'h00, "R8 irq clear clears arb");
    step(b(SG), 0, 8'h00, 8'h07, "R2 start generated");
    step('0, 1, 8'h00, 8'h03, "R9 irq cleared");
    step(b(SD), 0, 8'h00, 8'h14, "R8 repeated start while master");
    step('0, 1, 8'h00, 8'h00, "R8 cleared");
    step(b(SG), 0, 8'h00, 8'h07, "R2 start generated");
    step('0, 1, 8'h40, 8'h43, "R4 software sets start request");
    step(b(SD), 0, 8'h00, 8'h41, "R8 start with request high no arb");
    step(b(SCL), 0, 8'h00, 8'h54, "R8 scl low fault");
    step('0, 1, 8'h00, 8'h00, "R8 cleared");
    step(b(SG), 0, 8'h00, 8'h07, "R2 start generated");
    step('0, 1, 8'h00, 8'h03, "R9 irq cleared");
    step(b(PD), 0, 8'h00, 8'h84, "R5 R2 arbitration lost to stop");
    step('0, 1, 8'h00, 8'h00, "R9 cleared");
    step(b(SG), 0, 8'h00, 8'h07, "R2 start generated");
    step(b(TX), 1, 8'h00, 8'h07, "R10 R9 byte sent beats irq clear");
    step(b(AM), 1, 8'h00, 8'h47, "R10 address match beats sta clear");
    step(b(SCL), 1, 8'h00, 8'h14, "R10 arb fault beats irq clear");
    do_reset("R1 reset from busy state");
    step('0, 0, 8'h00, 8'h00, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule